// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is an SPI bus master that software drives through a small byte-wide register bus. Software programs a clock divider, a 16-bit command word and a control byte, then writes a transmit word into a byte-lane data register. Writing the lowest data byte launches one frame. The block shifts that frame out on the serial clock and data-out lines, samples the serial data-in line, and keeps the returned frame in a receive holding register.

The frame length can be any value from 8 to 16 bits, or 20, 24 or 32 bits. Clock polarity, clock phase and bit order are set per command word. A transmit-only control bit stops received frames from being captured. Because only a write from the master produces clocks, software that wants to receive must still write a dummy word. Three status flags report the buffers: transmit empty, receive full and overrun. They feed one interrupt line, gated by a per-flag enable. They also feed two request strobes that a DMA engine can follow.

Top module: `spim_regbus`

Register map (4-bit address): 0 control, 1 status, 2 divider N, 3 command low byte, 4 command high byte, 8 to 11 data bytes 0 to 3 (byte 0 least significant).

## Requirements
- R1: The serial clock toggles every N+1 clock cycles, where N is the value in the divider register (address 2). A frame of L bits keeps the select line low for exactly 2*L*(N+1) cycles. Between frames the serial clock rests at the command word's polarity bit (bit 1).
- R2: Command bits [11:8] (bits [3:0] of address 4) set the frame length L: codes 7 to 15 give code+1 bits, code 0 gives 20, code 1 gives 24, code 2 gives 32, and codes 3 to 6 give 8.
- R3: Phase bit 0 of the command word selects the capture edge. With phase 0, data is captured on the first clock edge of each bit and the next bit is driven on the second edge. With phase 1, the next bit is driven on the first edge and data is captured on the second. All four polarity/phase pairs move L bits both ways without error.
- R4: When command bit 12 (bit 4 of address 4) is set, the least significant bit is sent first. When it is clear, bit L-1 is sent first. In both cases the received frame is right-aligned.
- R5: A write to data byte 0 starts a frame only if control bit 6 (enable) and bit 3 (master) are set and status bit 5 (transmit empty) is set. Any other such write is ignored: no clock is produced and the frame in progress is unchanged. Transmit empty goes low when the frame starts and returns high when the frame ends.
- R6: When control bit 1 (transmit-only) is set, a completed frame does not set status bit 7 (receive full) and does not set overrun.
- R7: If a frame completes while receive full is still set, status bit 0 (overrun) is set and the held receive data is kept. Writing 0 to status bit 0 clears overrun; writing 1 leaves it unchanged.
- R8: Reading data bytes 0 to 3 returns the last captured frame, zero-extended. A read of byte 0 clears receive full.
- R9: The interrupt output is (rxfull AND control bit 7) OR (txempty AND control bit 5) OR (overrun AND control bit 4). The transmit request is txempty AND bit 5; the receive request is rxfull AND bit 7. Clearing an enable drops the matching output in the next cycle.
- R10: The active-low select is asserted while enable and master are set and either a frame is running or command bit 7 (keep) is set, so that with keep it stays low between frames.
- R11: After reset, control reads 0x00, status reads 0x20, select is high and the serial clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |
| irq | output | 1 | Interrupt request |
| tx_dreq | output | 1 | DMA transmit request |
| rx_dreq | output | 1 | DMA receive request |

## Verification
The shifting path is driven with all four polarity/phase pairs, both bit orders, and frame lengths 8, 12, 20, 24 and 32. Each run uses different divider values against a behavioural slave. Mismatched capture edges, a reversed bit order and wrong alignment of short or long frames each show up as a different corrupted word. The bench also uses distinct patterns to separate the flag paths: back-to-back frames without a read (overrun), a transmit-only frame, launch writes made while disabled, while not master or in mid-frame, and enables toggled while flags are held. A per-cycle model of the serial clock, select, interrupt and requests catches timing that is off by one half-period.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int MAX_BITS = 32;
    localparam int LEN_W    = $clog2(MAX_BITS + 1);
    localparam int NBYTES   = MAX_BITS / 8;

    localparam logic [3:0] A_CTRL = 4'h0;
    localparam logic [3:0] A_STAT = 4'h1;
    localparam logic [3:0] A_BAUD = 4'h2;
    localparam logic [3:0] A_CMDL = 4'h3;
    localparam logic [3:0] A_CMDH = 4'h4;
    localparam logic [3:0] A_DAT0 = 4'h8;

    typedef struct packed {
        logic rx_ie;
        logic en;
        logic tx_ie;
        logic err_ie;
        logic master;
        logic rsv2;
        logic tx_only;
        logic rsv0;
    } ctrl_t;

    typedef struct packed {
        logic [2:0] dly_en;
        logic       lsb_first;
        logic [3:0] len_code;
        logic       keep_sel;
        logic [4:0] rsv;
        logic       cpol;
        logic       cpha;
    } cmd_t;

    typedef struct packed {
        logic rxf;
        logic txe;
        logic ovr;
    } stat_t;

    function automatic logic [LEN_W-1:0] frame_bits(input logic [3:0] code);
        logic [LEN_W-1:0] n;
        case (code)
            4'd0:    n = LEN_W'(20);
            4'd1:    n = LEN_W'(24);
            4'd2:    n = LEN_W'(32);
            4'd3, 4'd4, 4'd5, 4'd6: n = LEN_W'(8);
            default: n = LEN_W'(code) + LEN_W'(1);
        endcase
        return n;
    endfunction

    function automatic logic [7:0] stat_byte(input stat_t s);
        return {s.rxf, 1'b0, s.txe, 4'b0000, s.ovr};
    endfunction

endpackage

// File: rtl/spim_baud.sv
module spim_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)      cnt <= '0;
        else if (cnt == div)  cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == div);

    assert_tick_bound_R1: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt <= div));
endmodule

// File: rtl/spim_shift.sv
module spim_shift
    import spim_pkg::*;
#(
    parameter int NB = MAX_BITS,
    parameter int LW = LEN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          abort,
    input  logic          tick,
    input  logic [NB-1:0] tx_word,
    input  logic [LW-1:0] len,
    input  logic          cpol,
    input  logic          cpha,
    input  logic          lsbf,
    input  logic          miso,
    output logic          busy,
    output logic          sclk,
    output logic          mosi,
    output logic          done,
    output logic [NB-1:0] rx_word
);
    localparam int HALF_W = LW + 1;

    logic [HALF_W-1:0] half;
    logic [NB-1:0]     tsh, rsh, rsh_nxt;
    logic [LW-1:0]     len_q;
    logic              pol_q, pha_q, lsb_q, sck_q;
    logic              leading, samp, shft, last;
    logic [LW-1:0]     rx_amt, tx_amt;

    assign leading = ~half[0];
    assign samp    = busy && tick && (pha_q ? ~leading : leading);
    assign shft    = busy && tick && (pha_q ? (leading && half != '0) : ~leading);
    assign last    = (half == ({len_q, 1'b0} - HALF_W'(1)));
    assign done    = busy && tick && last && !abort;

    always_comb begin
        rsh_nxt = rsh;
        if (samp) rsh_nxt = lsb_q ? {miso, rsh[NB-1:1]} : {rsh[NB-2:0], miso};
    end

    assign rx_amt  = LW'(NB) - len_q;
    assign tx_amt  = LW'(NB) - len;
    assign rx_word = lsb_q ? (rsh_nxt >> rx_amt) : rsh_nxt;
    assign sclk    = busy ? sck_q : cpol;
    assign mosi    = busy ? (lsb_q ? tsh[0] : tsh[NB-1]) : 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            half  <= '0;
            sck_q <= 1'b0;
            tsh   <= '0;
            rsh   <= '0;
            len_q <= '0;
            pol_q <= 1'b0;
            pha_q <= 1'b0;
            lsb_q <= 1'b0;
        end else if (abort) begin
            busy <= 1'b0;
        end else if (start && !busy) begin
            busy  <= 1'b1;
            half  <= '0;
            sck_q <= cpol;
            tsh   <= lsbf ? tx_word : (tx_word << tx_amt);
            rsh   <= '0;
            len_q <= len;
            pol_q <= cpol;
            pha_q <= cpha;
            lsb_q <= lsbf;
        end else if (busy && tick) begin
            half  <= half + 1'b1;
            sck_q <= ~sck_q;
            rsh   <= rsh_nxt;
            if (shft) tsh <= lsb_q ? (tsh >> 1) : (tsh << 1);
            if (last) begin
                busy  <= 1'b0;
                sck_q <= pol_q;
            end
        end
    end

    assert_half_bound_R2: assert property (@(posedge clk) disable iff (rst)
        busy |-> (half < {len_q, 1'b0}));
    assert_done_ends_R1: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);
endmodule

// File: rtl/spim_regs.sv
module spim_regs
    import spim_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [3:0]          bus_addr,
    input  logic [7:0]          bus_wdata,
    output logic [7:0]          bus_rdata,
    input  logic                busy,
    input  logic                done,
    input  logic [MAX_BITS-1:0] rx_word,
    output ctrl_t               ctrl_q,
    output cmd_t                cmd_q,
    output logic [DIV_W-1:0]    baud_q,
    output logic [MAX_BITS-1:0] tx_word,
    output logic                start,
    output logic                abort,
    output stat_t               stat_q
);
    logic [MAX_BITS-9:0] stage;
    logic [MAX_BITS-1:0] rx_hold;
    logic                run_ok, rd_clear;

    assign run_ok   = ctrl_q.en && ctrl_q.master;
    assign abort    = !run_ok;
    assign rd_clear = bus_rd && (bus_addr == A_DAT0);
    assign start    = bus_wr && (bus_addr == A_DAT0) && run_ok && stat_q.txe;
    assign tx_word  = {stage, bus_wdata};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            cmd_q   <= '0;
            baud_q  <= '0;
            stage   <= '0;
            rx_hold <= '0;
            stat_q  <= '{rxf: 1'b0, txe: 1'b1, ovr: 1'b0};
        end else begin
            if (bus_wr) begin
                case (bus_addr)
                    A_CTRL: ctrl_q <= ctrl_t'(bus_wdata & 8'hFA);
                    A_BAUD: baud_q <= DIV_W'(bus_wdata);
                    A_CMDL: cmd_q[7:0]  <= bus_wdata;
                    A_CMDH: cmd_q[15:8] <= bus_wdata;
                    A_STAT: if (!bus_wdata[0]) stat_q.ovr <= 1'b0;
                    default: ;
                endcase
                for (int b = 1; b < NBYTES; b++)
                    if (bus_addr == A_DAT0 + 4'(b)) stage[(b-1)*8 +: 8] <= bus_wdata;
            end

            if (start)                stat_q.txe <= 1'b0;
            else if (done || !run_ok) stat_q.txe <= 1'b1;

            if (done && !ctrl_q.tx_only) begin
                if (stat_q.rxf && !rd_clear) begin
                    stat_q.ovr <= 1'b1;
                end else begin
                    stat_q.rxf <= 1'b1;
                    rx_hold    <= rx_word;
                end
            end else if (rd_clear) begin
                stat_q.rxf <= 1'b0;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: bus_rdata = ctrl_q;
            A_STAT: bus_rdata = stat_byte(stat_q);
            A_BAUD: bus_rdata = 8'(baud_q);
            A_CMDL: bus_rdata = cmd_q[7:0];
            A_CMDH: bus_rdata = cmd_q[15:8];
            default: ;
        endcase
        for (int b = 0; b < NBYTES; b++)
            if (bus_addr == A_DAT0 + 4'(b)) bus_rdata = rx_hold[b*8 +: 8];
    end

    assert_txe_busy_R5: assert property (@(posedge clk) disable iff (rst)
        busy |-> !stat_q.txe);
    assert_txonly_norx_R6: assert property (@(posedge clk) disable iff (rst)
        (done && ctrl_q.tx_only && !rd_clear) |=> (stat_q.rxf == $past(stat_q.rxf)));
    assert_ovr_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (done && !ctrl_q.tx_only && stat_q.rxf && !rd_clear) |=> (stat_q.ovr && $stable(rx_hold)));
    assert_rdclr_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_clear && !done) |=> !stat_q.rxf);
endmodule

// File: rtl/spim_regbus.sv
module spim_regbus
    import spim_pkg::*;
#(
    parameter int CLKDIV_W = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [3:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       sclk,
    output logic       mosi,
    input  logic       miso,
    output logic       ss_n,
    output logic       irq,
    output logic       tx_dreq,
    output logic       rx_dreq
);
    ctrl_t                ctrl_q;
    cmd_t                 cmd_q;
    stat_t                stat_q;
    logic [CLKDIV_W-1:0]  baud_q;
    logic [MAX_BITS-1:0]  tx_word, rx_word;
    logic                 start, abort, busy, done, tick;

    spim_regs #(.DIV_W(CLKDIV_W)) u_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy(busy), .done(done), .rx_word(rx_word),
        .ctrl_q(ctrl_q), .cmd_q(cmd_q), .baud_q(baud_q), .tx_word(tx_word),
        .start(start), .abort(abort), .stat_q(stat_q)
    );

    spim_baud #(.DIV_W(CLKDIV_W)) u_baud (
        .clk(clk), .rst(rst), .run(busy), .div(baud_q), .tick(tick)
    );

    spim_shift u_shift (
        .clk(clk), .rst(rst), .start(start), .abort(abort), .tick(tick),
        .tx_word(tx_word), .len(frame_bits(cmd_q.len_code)),
        .cpol(cmd_q.cpol), .cpha(cmd_q.cpha), .lsbf(cmd_q.lsb_first),
        .miso(miso), .busy(busy), .sclk(sclk), .mosi(mosi), .done(done),
        .rx_word(rx_word)
    );

    assign ss_n    = !(ctrl_q.en && ctrl_q.master && (busy || cmd_q.keep_sel));
    assign tx_dreq = stat_q.txe && ctrl_q.tx_ie;
    assign rx_dreq = stat_q.rxf && ctrl_q.rx_ie;
    assign irq     = tx_dreq || rx_dreq || (stat_q.ovr && ctrl_q.err_ie);

    assert_ss_busy_R10: assert property (@(posedge clk) disable iff (rst)
        busy |-> !ss_n);
    assert_dreq_irq_R9: assert property (@(posedge clk) disable iff (rst)
        (tx_dreq || rx_dreq) |-> irq);
endmodule

// File: tb/spim_regbus_test.sv
module spim_regbus_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0, rst = 1'b1;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       sclk, mosi, ss_n, irq, tx_dreq, rx_dreq;
    logic       miso = 1'b0;

    int n_vec = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spim_regbus uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n), .irq(irq),
        .tx_dreq(tx_dreq), .rx_dreq(rx_dreq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int len_of(input logic [3:0] c);
        if (c >= 7) return int'(c) + 1;
        if (c == 0) return 20;
        if (c == 1) return 24;
        if (c == 2) return 32;
        return 8;
    endfunction

    function automatic logic [31:0] mask_of(input int n);
        return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
    endfunction

    // ---------------- behavioural slave ----------------
    logic [31:0] s_word = '0, s_cap = '0;
    int          s_len = 8, s_iidx = 0, s_oidx = 0, s_lc = 0;
    bit          s_lsb = 0, s_pha = 0, s_pol = 0;
    logic        s_prev = 1'b0;

    function automatic int pos_of(input int i);
        return s_lsb ? i : (s_len - 1 - i);
    endfunction

    // ---------------- reference model ----------------
    logic [7:0]  m_ctrl = '0, m_baud = '0;
    logic [15:0] m_cmd = '0;
    bit          m_busy = 0, m_txe = 1, m_rxf = 0, m_ovr = 0, m_pol = 0;
    int          m_k = 0, m_total = 0;
    logic [31:0] m_rx = '0;

    always @(posedge clk) begin
        bit run_ok, fin, rdclr, go;
        if (rst) begin
            m_ctrl = '0; m_baud = '0; m_cmd = '0;
            m_busy = 0; m_txe = 1; m_rxf = 0; m_ovr = 0; m_rx = '0; m_k = 0;
        end else begin
            run_ok = m_ctrl[6] && m_ctrl[3];
            rdclr  = bus_rd && bus_addr == 4'h8;
            go     = bus_wr && bus_addr == 4'h8 && run_ok && m_txe;
            fin    = 0;
            if (m_busy && !run_ok) m_busy = 0;
            else if (m_busy) begin
                m_k++;
                if (m_k == m_total) begin m_busy = 0; fin = 1; end
            end
            if (!run_ok || fin) m_txe = 1;
            if (bus_wr && bus_addr == 4'h1 && !bus_wdata[0]) m_ovr = 0;
            if (fin && !m_ctrl[1]) begin
                if (m_rxf && !rdclr) m_ovr = 1;
                else begin m_rxf = 1; m_rx = s_word & mask_of(s_len); end
            end else if (rdclr) m_rxf = 0;
            if (go) begin
                m_busy = 1; m_k = 0; m_txe = 0; m_pol = m_cmd[1];
                m_total = 2 * len_of(m_cmd[11:8]) * (int'(m_baud) + 1);
            end
            if (bus_wr) begin
                case (bus_addr)
                    4'h0: m_ctrl = bus_wdata & 8'hFA;
                    4'h2: m_baud = bus_wdata;
                    4'h3: m_cmd[7:0] = bus_wdata;
                    4'h4: m_cmd[15:8] = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [7:0] exp_rd(input logic [3:0] a);
        case (a)
            4'h0: return m_ctrl;
            4'h1: return {m_rxf, 1'b0, m_txe, 4'b0, m_ovr};
            4'h2: return m_baud;
            4'h3: return m_cmd[7:0];
            4'h4: return m_cmd[15:8];
            4'h8: return m_rx[7:0];
            4'h9: return m_rx[15:8];
            4'hA: return m_rx[23:16];
            4'hB: return m_rx[31:24];
            default: return 8'h00;
        endcase
    endfunction

    // per-cycle comparison and slave action, away from the active edge
    always @(negedge clk) begin
        bit lead;
        int q;
        if (!rst) begin
            q = (m_k / (int'(m_baud) + 1)) % 2;
            chk("R1 sclk", {31'b0, sclk}, {31'b0, m_busy ? (m_pol ^ q[0]) : m_cmd[1]});
            chk("R10 ss_n", {31'b0, ss_n},
                {31'b0, !(m_ctrl[6] && m_ctrl[3] && (m_busy || m_cmd[7]))});
            chk("R9 irq", {31'b0, irq},
                {31'b0, (m_rxf && m_ctrl[7]) || (m_txe && m_ctrl[5]) || (m_ovr && m_ctrl[4])});
            chk("R9 tx_dreq", {31'b0, tx_dreq}, {31'b0, m_txe && m_ctrl[5]});
            chk("R9 rx_dreq", {31'b0, rx_dreq}, {31'b0, m_rxf && m_ctrl[7]});
            if (ss_n == 1'b0 && sclk != s_prev) begin
                lead = (s_prev == s_pol);
                if (lead == !s_pha) begin
                    if (s_iidx < s_len) s_cap[pos_of(s_iidx)] = mosi;
                    s_iidx++;
                end else if (s_pha) begin
                    s_lc++;
                    if (s_lc - 1 < s_len) miso = s_word[pos_of(s_lc - 1)];
                end else begin
                    s_oidx++;
                    if (s_oidx < s_len) miso = s_word[pos_of(s_oidx)];
                end
            end
            s_prev = sclk;
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input string req, output logic [7:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        chk(req, {24'b0, v}, {24'b0, exp_rd(a)});
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic cfg(input bit pol, input bit pha, input bit lsb,
                       input logic [3:0] code, input logic [7:0] baud, input bit keep);
        s_pol = pol; s_pha = pha; s_lsb = lsb; s_len = len_of(code);
        wr(4'h2, baud);
        wr(4'h3, {keep, 5'b0, pol, pha});
        wr(4'h4, {3'b0, lsb, code});
    endtask

    // dur < 0 skips the select-length check
    task automatic xfer(input logic [31:0] tx, input logic [31:0] sw, input string req,
                        input int dur, input bit dup);
        int cnt;
        s_word = sw; s_cap = '0; s_iidx = 0; s_oidx = 0; s_lc = 0; s_prev = s_pol;
        miso = sw[pos_of(0)];
        wr(4'hB, tx[31:24]); wr(4'hA, tx[23:16]); wr(4'h9, tx[15:8]); wr(4'h8, tx[7:0]);
        if (dup) wr(4'h8, ~tx[7:0]);
        cnt = 0;
        if (dur >= 0) begin
            while (ss_n === 1'b0 && cnt < 100000) begin cnt++; @(negedge clk); end
            chk("R1 frame length", cnt, dur);
        end else begin
            while (m_busy && cnt < 100000) begin cnt++; @(negedge clk); end
        end
        if (dur != 0) chk(req, s_cap & mask_of(s_len), tx & mask_of(s_len));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL R1 watchdog act=hung exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        rd(4'h0, "R11 ctrl", v);  chk("R11 ctrl literal", {24'b0, v}, 32'h00);
        rd(4'h1, "R11 stat", v);  chk("R11 stat literal", {24'b0, v}, 32'h20);
        chk("R11 ss_n", {31'b0, ss_n}, 32'h1);
        chk("R11 sclk", {31'b0, sclk}, 32'h0);

        wr(4'h0, 8'h48);
        // R3 mode 0, 8 bits, MSB first, N=1
        cfg(0, 0, 0, 4'd7, 8'd1, 0);
        xfer(32'h0000_00A5, 32'h0000_003C, "R3 mode0 mosi", 2*8*2, 0);
        rd(4'h1, "R8 stat full", v);  chk("R8 stat full lit", {24'b0, v}, 32'hA0);
        rd(4'h8, "R8 data", v);       chk("R8 data lit", {24'b0, v}, 32'h3C);
        rd(4'h1, "R8 cleared", v);    chk("R8 cleared lit", {24'b0, v}, 32'h20);

        // R4 mode 3, 12 bits, LSB first, N=0
        cfg(1, 1, 1, 4'd11, 8'd0, 0);
        xfer(32'hFFFF_F5A3, 32'h0000_0ABC, "R4 lsb mode3 mosi", 2*12, 0);
        rd(4'h9, "R4 byte1", v);      chk("R4 byte1 lit", {24'b0, v}, 32'h0A);
        rd(4'h8, "R4 byte0", v);      chk("R4 byte0 lit", {24'b0, v}, 32'hBC);

        // R2 20-bit frame, mode 1, N=2, garbage in upper byte
        cfg(0, 1, 0, 4'd0, 8'd2, 0);
        xfer(32'hAB0F_1234, 32'h0009_8765, "R3 mode1 20b mosi", 2*20*3, 0);
        rd(4'hB, "R2 20b byte3", v);  chk("R2 20b byte3 lit", {24'b0, v}, 32'h00);
        rd(4'hA, "R2 20b byte2", v);  chk("R2 20b byte2 lit", {24'b0, v}, 32'h09);
        rd(4'h8, "R2 20b byte0", v);

        // R2 32-bit frame, mode 2
        cfg(1, 0, 0, 4'd2, 8'd0, 0);
        xfer(32'hDEAD_BEEF, 32'h1357_9BDF, "R2 32b mosi", 2*32, 0);
        rd(4'hB, "R2 32b byte3", v);  chk("R2 32b byte3 lit", {24'b0, v}, 32'h13);
        rd(4'h8, "R2 32b byte0", v);  chk("R2 32b byte0 lit", {24'b0, v}, 32'hDF);

        // R4 24-bit LSB first, mode 0
        cfg(0, 0, 1, 4'd1, 8'd0, 0);
        xfer(32'h00C0_FFEE, 32'h77AB_CDEF, "R4 24b lsb mosi", 2*24, 0);
        rd(4'hA, "R4 24b byte2", v);  chk("R4 24b byte2 lit", {24'b0, v}, 32'hAB);
        rd(4'hB, "R4 24b byte3", v);  chk("R4 24b byte3 lit", {24'b0, v}, 32'h00);
        rd(4'h8, "R4 24b byte0", v);

        // R6 transmit-only
        cfg(0, 0, 0, 4'd7, 8'd0, 0);
        wr(4'h0, 8'h4A);
        xfer(32'h0000_0081, 32'h0000_00FF, "R6 txonly mosi", 16, 0);
        rd(4'h1, "R6 stat", v);       chk("R6 no rxfull", {24'b0, v}, 32'h20);
        wr(4'h0, 8'h48);

        // R7 overrun
        xfer(32'h11, 32'h22, "R7 first", 16, 0);
        xfer(32'h33, 32'h44, "R7 second", 16, 0);
        rd(4'h1, "R7 stat ovr", v);   chk("R7 ovr lit", {24'b0, v}, 32'hA1);
        rd(4'h8, "R7 data kept", v);  chk("R7 data kept lit", {24'b0, v}, 32'h22);
        wr(4'h1, 8'h01);
        rd(4'h1, "R7 write1", v);     chk("R7 write1 lit", {24'b0, v}, 32'h21);
        wr(4'h1, 8'h00);
        rd(4'h1, "R7 cleared", v);    chk("R7 cleared lit", {24'b0, v}, 32'h20);

        // R5 launch blocked when not enabled or not master
        wr(4'h0, 8'h08);
        xfer(32'h55, 32'h66, "R5 no enable", 0, 0);
        rd(4'h1, "R5 stat ne", v);    chk("R5 stat ne lit", {24'b0, v}, 32'h20);
        wr(4'h0, 8'h40);
        xfer(32'h55, 32'h66, "R5 no master", 0, 0);
        rd(4'h1, "R5 stat nm", v);    chk("R5 stat nm lit", {24'b0, v}, 32'h20);
        wr(4'h0, 8'h48);
        // R5 write during a frame is ignored
        cfg(0, 0, 0, 4'd7, 8'd3, 0);
        xfer(32'h0F, 32'hC3, "R5 busy write ignored", -1, 1);
        rd(4'h8, "R5 rx", v);         chk("R5 rx lit", {24'b0, v}, 32'hC3);
        rd(4'h1, "R5 stat after", v); chk("R5 stat after lit", {24'b0, v}, 32'h20);

        // R9 interrupt and request gating
        wr(4'h0, 8'hE8);
        chk("R9 irq txe", {31'b0, irq}, 32'h1);
        chk("R9 txreq", {31'b0, tx_dreq}, 32'h1);
        chk("R9 rxreq idle", {31'b0, rx_dreq}, 32'h0);
        cfg(0, 0, 0, 4'd7, 8'd0, 0);
        xfer(32'h5A, 32'hA5, "R9 frame", 16, 0);
        chk("R9 rxreq set", {31'b0, rx_dreq}, 32'h1);
        wr(4'h0, 8'h48);
        chk("R9 irq masked", {31'b0, irq}, 32'h0);
        chk("R9 rxreq masked", {31'b0, rx_dreq}, 32'h0);
        xfer(32'h5B, 32'hB5, "R9 overrun frame", 16, 0);
        wr(4'h0, 8'h58);
        chk("R9 irq ovr", {31'b0, irq}, 32'h1);
        wr(4'h1, 8'h00);
        rd(4'h8, "R9 drain", v);
        wr(4'h0, 8'h48);

        // R10 keep select between frames
        cfg(0, 0, 0, 4'd7, 8'd0, 1);
        chk("R10 keep idle", {31'b0, ss_n}, 32'h0);
        xfer(32'h96, 32'h69, "R10 keep frame", -1, 0);
        chk("R10 keep after", {31'b0, ss_n}, 32'h0);
        cfg(0, 0, 0, 4'd7, 8'd0, 0);
        chk("R10 release", {31'b0, ss_n}, 32'h1);

        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule